// File: doc/BRIEF.md
# Vector Byte Table-Lookup Unit

This unit carries out byte-wise table lookups over its own bank of 32 vector registers, each 128 bits wide. A caller presents a 32-bit instruction word together with a one-cycle start strobe. The unit treats one to four consecutive registers, starting at a base register, as a single byte table. Each byte of an index register picks one table byte, and that byte lands in the same lane of the destination register.

Two variants are selected by an instruction flag. In the zeroing variant, an index that falls outside the table yields 0x00. In the merging variant, such an index leaves the old destination byte in place. A width flag selects either a full 16-lane operation or an 8-lane one. In the 8-lane mode the upper half of the destination is cleared.

The table may run past register 31 and wrap to register 0. Every source value is captured before the single write-back, so the destination may safely be one of the table or index registers. An external port loads and inspects registers while the unit is idle. A one-cycle done pulse marks the write-back.

Top module: `vtbl_unit`

## Requirements
- R1: Instruction fields are taken as: destination register bits 4:0, table base register bits 9:5, index register bits 20:16, merge flag bit 12, length code bits 14:13, full-width flag bit 30. All other bits are ignored.
- R2: The table holds (length code + 1) × 16 bytes. An index byte hits only when it is unsigned-less-than that size. Any larger value, including 64 and above, is a miss.
- R3: A hitting index byte v selects register (base + v[7:4]) mod 32 and byte v[3:0] of that register. Byte k of a register is bits 8k+7:8k. Index byte i produces result byte i.
- R4: On a miss, the result byte is 0x00 when the merge flag is 0. It is the destination's prior byte when the merge flag is 1.
- R5: With the full-width flag at 0, only lanes 0 to 7 are looked up, and bytes 15:8 of the destination are written as zero in both variants. With the flag at 1, all 16 lanes are looked up.
- R6: All lookups use register values from before the operation, even when the destination equals the index register or a table register.
- R7: Counting the clock edge that samples start as edge 0, done is high for exactly one cycle after edge 4 + length code. The destination is updated at that same edge, and busy is high from edge 0 until that edge.
- R8: A start strobe that arrives while busy is high is ignored. It causes no extra operation and no extra done pulse.
- R9: A write on the external port takes effect at the next edge only while busy is low. While busy is high it is dropped. The external read data always shows the addressed register combinationally.
- R10: Synchronous active-low reset clears busy, done and every register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation with `instr` (sampled when idle) |
| instr | input | 32 | Instruction word carrying the operation fields |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at write-back |
| ext_we | input | 1 | External register write enable |
| ext_addr | input | 5 | External register address (read and write) |
| ext_wdata | input | 128 | External write data |
| ext_rdata | output | 128 | Contents of register `ext_addr` |

## Verification
After start is sampled, the destination value and done are due 4 + length-code edges later, so the latency runs from 4 to 7 edges. External writes are due one edge after they are applied. The bench drives every input on the falling edge and samples on the following falling edge. It counts rising edges from the edge that takes start to the first half-cycle in which done is seen, and compares that count with 4 + length code for each vector. Results are read through the combinational read port only after done, and after a quiet stretch that follows an ignored start or write. This confirms that nothing late or extra arrives.

// File: rtl/vtbl_pkg.sv
// Shared constants, state encoding and instruction decode for the
// vector byte table-lookup unit. Assumes 5-bit register numbers.
package vtbl_pkg;
    localparam int NREG_D    = 32;
    localparam int VBYTES_D  = 16;
    localparam int MAXTAB_D  = 4;
    localparam int AW_D      = $clog2(NREG_D);
    localparam int SW_D      = $clog2(MAXTAB_D);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDX,
        ST_DST,
        ST_TAB,
        ST_WB
    } tbl_state_t;

    typedef struct packed {
        logic [AW_D-1:0] rd;
        logic [AW_D-1:0] rn;
        logic [AW_D-1:0] rm;
        logic            keep;
        logic [SW_D-1:0] len;
        logic            full;
    } tbl_op_t;

    // Pull the operation fields out of an instruction word.
    function automatic tbl_op_t decode_op(input logic [31:0] w);
        tbl_op_t o;
        o.rd   = w[4:0];
        o.rn   = w[9:5];
        o.rm   = w[20:16];
        o.keep = w[12];
        o.len  = w[14:13];
        o.full = w[30];
        return o;
    endfunction
endpackage

// File: rtl/vtbl_regfile.sv
// Register bank for the lookup unit: one internal read port, one
// external read port, and a write port shared between write-back and
// the external port. Assumes write-back and external writes never
// coincide; the external write is dropped while `lock` is high.
module vtbl_regfile #(
    parameter int NREG = vtbl_pkg::NREG_D,
    parameter int VW   = vtbl_pkg::VBYTES_D * 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock,
    input  logic          ext_we,
    input  logic [AW-1:0] ext_addr,
    input  logic [VW-1:0] ext_wdata,
    output logic [VW-1:0] ext_rdata,
    input  logic          int_we,
    input  logic [AW-1:0] int_waddr,
    input  logic [VW-1:0] int_wdata,
    input  logic [AW-1:0] int_raddr,
    output logic [VW-1:0] int_rdata
);
    logic [VW-1:0] mem [NREG];

    // Storage update: reset clear, write-back first, else idle external write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) mem[r] <= '0;
        end else if (int_we) begin
            mem[int_waddr] <= int_wdata;
        end else if (ext_we && !lock) begin
            mem[ext_addr] <= ext_wdata;
        end
    end

    assign ext_rdata = mem[ext_addr];
    assign int_rdata = mem[int_raddr];

    // R9
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !int_we) |=> ((ext_addr != $past(ext_addr)) || $stable(ext_rdata)));
endmodule

// File: rtl/vtbl_ctrl.sv
// Sequencer: accepts start when idle, then reads the index register,
// the destination register and len+1 table registers (base+k mod NREG),
// one per cycle, followed by one write-back cycle and a done pulse.
module vtbl_ctrl
    import vtbl_pkg::*;
#(
    parameter int NREG    = NREG_D,
    parameter int MAX_TAB = MAXTAB_D,
    localparam int AW     = $clog2(NREG),
    localparam int SW     = $clog2(MAX_TAB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   instr,
    output tbl_state_t    state,
    output tbl_op_t       op,
    output logic [SW-1:0] cnt,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          done
);
    // State, latched operation, table counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            op    <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    op    <= decode_op(instr);
                    state <= ST_IDX;
                end
                ST_IDX: state <= ST_DST;
                ST_DST: begin
                    cnt   <= '0;
                    state <= ST_TAB;
                end
                ST_TAB: begin
                    if (cnt == op.len) state <= ST_WB;
                    else               cnt   <= cnt + 1'b1;
                end
                ST_WB: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read address for the register being fetched this cycle.
    always_comb begin
        unique case (state)
            ST_IDX:  rd_addr = op.rm;
            ST_DST:  rd_addr = op.rd;
            ST_TAB:  rd_addr = op.rn + AW'(cnt);
            default: rd_addr = op.rd;
        endcase
    end

    assign busy = (state != ST_IDLE);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_IDLE) |=> (state == ST_IDX));
    // R2
    tab_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAB) |-> (cnt <= op.len));
endmodule

// File: rtl/vtbl_lane.sv
// One result byte: range-checks its index byte against the table size,
// picks the table byte on a hit, else zero or the old destination byte.
// Lanes in the upper half yield zero unless the full-width flag is set.
module vtbl_lane #(
    parameter int LANE    = 0,
    parameter int VBYTES  = vtbl_pkg::VBYTES_D,
    parameter int MAX_TAB = vtbl_pkg::MAXTAB_D,
    localparam int VW     = VBYTES * 8,
    localparam int BW     = $clog2(VBYTES),
    localparam int SW     = $clog2(MAX_TAB),
    localparam int LW     = 9
) (
    input  logic [7:0]            idx_byte,
    input  logic [7:0]            dst_byte,
    input  logic [MAX_TAB*VW-1:0] table_bits,
    input  logic [SW-1:0]         len,
    input  logic                  keep,
    input  logic                  full,
    output logic [7:0]            res_byte
);
    localparam bit UPPER = (LANE >= VBYTES / 2);

    logic [LW-1:0] limit;
    logic          hit;
    logic          active;
    logic [7:0]    picked;
    logic [BW-1:0] bsel;
    logic [SW-1:0] slot;

    // Table size, hit test and byte selection.
    always_comb begin
        limit  = (LW'(len) + LW'(1)) << BW;
        hit    = ({1'b0, idx_byte} < limit);
        bsel   = idx_byte[BW-1:0];
        slot   = idx_byte[BW+SW-1:BW];
        picked = table_bits[{slot, bsel, 3'b000} +: 8];
        active = !UPPER || full;
    end

    // Result byte selection: inactive, hit, or miss handling.
    always_comb begin
        if (!active)   res_byte = 8'h00;
        else if (hit)  res_byte = picked;
        else if (keep) res_byte = dst_byte;
        else           res_byte = 8'h00;
    end
endmodule

// File: rtl/vtbl_unit.sv
// Top of the vector byte table-lookup unit. Captures the index,
// destination and table registers into holding registers, computes all
// lanes from those captures, and writes the result back in one cycle.
// Assumes the caller loads registers through the external port only
// while busy is low (later writes are dropped).
module vtbl_unit
    import vtbl_pkg::*;
#(
    parameter int NREG    = NREG_D,
    parameter int VBYTES  = VBYTES_D,
    parameter int MAX_TAB = MAXTAB_D,
    localparam int AW     = $clog2(NREG),
    localparam int VW     = VBYTES * 8,
    localparam int SW     = $clog2(MAX_TAB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   instr,
    output logic          busy,
    output logic          done,
    input  logic          ext_we,
    input  logic [AW-1:0] ext_addr,
    input  logic [VW-1:0] ext_wdata,
    output logic [VW-1:0] ext_rdata
);
    tbl_state_t    state;
    tbl_op_t       op;
    logic [SW-1:0] cnt;
    logic [AW-1:0] rd_addr;
    logic [VW-1:0] rd_data;
    logic [VW-1:0] idx_q;
    logic [VW-1:0] dst_q;
    logic [VW-1:0] tab_q [MAX_TAB];
    logic [MAX_TAB*VW-1:0] tab_flat;
    logic [VW-1:0] result;

    vtbl_ctrl #(.NREG(NREG), .MAX_TAB(MAX_TAB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .state(state), .op(op), .cnt(cnt), .rd_addr(rd_addr),
        .busy(busy), .done(done)
    );

    vtbl_regfile #(.NREG(NREG), .VW(VW)) u_rf (
        .clk(clk), .rst_n(rst_n), .lock(busy),
        .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata),
        .int_we(state == ST_WB), .int_waddr(op.rd), .int_wdata(result),
        .int_raddr(rd_addr), .int_rdata(rd_data)
    );

    // Capture index and destination registers in their fetch cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            dst_q <= '0;
        end else begin
            if (state == ST_IDX) idx_q <= rd_data;
            if (state == ST_DST) dst_q <= rd_data;
        end
    end

    for (genvar s = 0; s < MAX_TAB; s++) begin : g_tab
        // Capture table register s while the counter points at it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 tab_q[s] <= '0;
            else if (state == ST_TAB && cnt == SW'(s))  tab_q[s] <= rd_data;
        end
        assign tab_flat[s*VW +: VW] = tab_q[s];
    end

    for (genvar i = 0; i < VBYTES; i++) begin : g_lane
        vtbl_lane #(.LANE(i), .VBYTES(VBYTES), .MAX_TAB(MAX_TAB)) u_lane (
            .idx_byte(idx_q[8*i +: 8]),
            .dst_byte(dst_q[8*i +: 8]),
            .table_bits(tab_flat),
            .len(op.len),
            .keep(op.keep),
            .full(op.full),
            .res_byte(result[8*i +: 8])
        );
    end

    // R5
    half_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB && !op.full) |=> (ext_addr != $past(op.rd)) ||
            (ext_rdata[VW-1:VW/2] == '0));
endmodule

// File: tb/sim_vtbl_unit.sv
`timescale 1ns/1ps
module sim_vtbl_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  instr = '0;
    logic         busy, done;
    logic         ext_we = 1'b0;
    logic [4:0]   ext_addr = '0;
    logic [127:0] ext_wdata = '0;
    logic [127:0] ext_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [127:0] mdl [32];

    always #2 clk = ~clk;

    vtbl_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .busy(busy), .done(done), .ext_we(ext_we), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    typedef struct packed {
        logic         q;
        logic         tbx;
        logic [1:0]   len;
        logic [4:0]   rd;
        logic [4:0]   rn;
        logic [4:0]   rm;
        logic [127:0] idx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 2'd0, 5'd20, 5'd2,  5'd10, 128'h000102030405060708090a0b0c0d0e0f},
        '{1'b1, 1'b0, 2'd3, 5'd21, 5'd30, 5'd11, 128'h3f3e30201f10000f41404080ff7f3c05},
        '{1'b1, 1'b1, 2'd1, 5'd22, 5'd5,  5'd12, 128'h201f00ff3011210a40339912013e2f1e},
        '{1'b0, 1'b1, 2'd2, 5'd23, 5'd31, 5'd13, 128'h05060708090a0b0c2f30ff1020003122},
        '{1'b0, 1'b0, 2'd1, 5'd24, 5'd0,  5'd14, 128'h01020304050607081f20211000ee0f17},
        '{1'b1, 1'b1, 2'd3, 5'd8,  5'd7,  5'd9,  128'h3c2d1e0f10203040506070800c1b2a39},
        '{1'b1, 1'b0, 2'd0, 5'd3,  5'd3,  5'd3,  128'h0f0e0d0c0b0a09081011ff0706050403},
        '{1'b1, 1'b1, 2'd0, 5'd15, 5'd16, 5'd15, 128'h0010203040506070f00f0e0d0c0b0a09}
    };

    function automatic logic [31:0] mk(logic q, logic tbx, logic [1:0] len,
                                       logic [4:0] rd, logic [4:0] rn, logic [4:0] rm);
        logic [31:0] w;
        w = 32'h0e000000;
        w[30] = q; w[12] = tbx; w[14:13] = len;
        w[4:0] = rd; w[9:5] = rn; w[20:16] = rm;
        return w;
    endfunction

    function automatic logic [127:0] model(logic q, logic tbx, logic [1:0] len,
                                           logic [4:0] rd, logic [4:0] rn, logic [4:0] rm);
        logic [127:0] res;
        logic [7:0]   b;
        logic [4:0]   r;
        res = tbx ? mdl[rd] : '0;
        for (int i = 0; i < (q ? 16 : 8); i++) begin
            b = mdl[rm][8*i +: 8];
            if (int'(b) < (int'(len) + 1) * 16) begin
                r = rn + 5'(b >> 4);
                res[8*i +: 8] = mdl[r][8*(b % 16) +: 8];
            end
        end
        if (!q) res[127:64] = '0;
        return res;
    endfunction

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ext_write(logic [4:0] a, logic [127:0] d);
        @(negedge clk);
        ext_we = 1'b1; ext_addr = a; ext_wdata = d;
        @(negedge clk);
        ext_we = 1'b0;
        mdl[a] = d;
    endtask

    task automatic ext_read(logic [4:0] a, output logic [127:0] d);
        @(negedge clk);
        ext_addr = a;
        #1 d = ext_rdata;
    endtask

    // Issue one operation and return the edge count until done is seen.
    task automatic run_op(logic [31:0] w, output int lat);
        @(negedge clk);
        start = 1'b1; instr = w;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_tests++; n_fail++;
        $display("FAIL R7 watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] rv, ev, keep26;
        int lat, extra;
        for (int r = 0; r < 32; r++) mdl[r] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0 && done == 1'b0, "R10 busy/done after reset", {126'd0, busy, done}, '0);
        ext_read(5'd17, rv);
        chk(rv == '0, "R10 register cleared by reset", rv, '0);

        // Load a distinct pattern into every register (R9 idle writes).
        for (int r = 0; r < 32; r++) begin
            logic [127:0] d;
            for (int k = 0; k < 16; k++) d[8*k +: 8] = 8'(r * 37 + k * 11 + 5);
            ext_write(5'(r), d);
        end
        ext_read(5'd29, rv);
        chk(rv == mdl[29], "R9 idle external write visible", rv, mdl[29]);

        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            ext_write(VECS[v].rm, VECS[v].idx);
            ev = model(VECS[v].q, VECS[v].tbx, VECS[v].len, VECS[v].rd, VECS[v].rn, VECS[v].rm);
            run_op(mk(VECS[v].q, VECS[v].tbx, VECS[v].len, VECS[v].rd, VECS[v].rn, VECS[v].rm), lat);
            chk(lat == 4 + int'(VECS[v].len), $sformatf("R7 latency vec %0d", v),
                128'(lat), 128'(4 + int'(VECS[v].len)));
            mdl[VECS[v].rd] = ev;
            ext_read(VECS[v].rd, rv);
            chk(rv == ev, $sformatf("R1 R2 R3 R4 R5 R6 result vec %0d", v), rv, ev);
        end

        // R8 and R9: start and external write while busy are dropped.
        keep26 = mdl[26];
        ev = model(1'b1, 1'b0, 2'd3, 5'd25, 5'd28, 5'd11);
        @(negedge clk);
        start = 1'b1; instr = mk(1'b1, 1'b0, 2'd3, 5'd25, 5'd28, 5'd11);
        @(negedge clk);
        start = 1'b1; instr = mk(1'b1, 1'b0, 2'd0, 5'd26, 5'd2, 5'd10);
        ext_we = 1'b1; ext_addr = 5'd27; ext_wdata = {8{16'hbeef}};
        @(negedge clk);
        start = 1'b0; ext_we = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        mdl[25] = ev;
        extra = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R8 no extra done for ignored start", 128'(extra), '0);
        ext_read(5'd26, rv);
        chk(rv == keep26, "R8 ignored start left register untouched", rv, keep26);
        ext_read(5'd27, rv);
        chk(rv == mdl[27], "R9 busy external write dropped", rv, mdl[27]);
        ext_read(5'd25, rv);
        chk(rv == ev, "R3 wrapped four-register table result", rv, ev);

        // R1: unrelated instruction bits do not change the operation.
        ext_write(5'd4, 128'h00ff3f2f1f0f4030201000112233a0b1);
        ev = model(1'b1, 1'b1, 2'd3, 5'd6, 5'd29, 5'd4);
        run_op(mk(1'b1, 1'b1, 2'd3, 5'd6, 5'd29, 5'd4) ^ 32'h0180_0c00, lat);
        mdl[6] = ev;
        ext_read(5'd6, rv);
        chk(rv == ev, "R1 other instruction bits ignored", rv, ev);

        // R2: index 0x40 and above misses even for the largest table (zero variant).
        ext_write(5'd1, {8{16'h4080}});
        run_op(mk(1'b1, 1'b0, 2'd3, 5'd2, 5'd0, 5'd1), lat);
        mdl[2] = '0;
        ext_read(5'd2, rv);
        chk(rv == '0, "R2 R4 out-of-range indices give zero", rv, '0);

        @(negedge clk);
        chk(busy == 1'b0, "R7 idle after completion", 128'(busy), '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule